// File: doc/BRIEF.md
# Two-Group Prioritized Interrupt Controller

This block gathers up to fifteen interrupt lines, numbered 1 to 15, for a single processor. A rising edge on a line latches a request. Software gives each line a mask bit and a group bit. The group bit places the line in a high or a low priority group. A line can also be raised from software through a force register, or set up so that its input edges land in the force register rather than in the pending register.

The processor sees a 4-bit request level. If any enabled source in the high group is active, the level is the highest-numbered such source. Otherwise it is the highest-numbered active source in the low group. The processor acknowledges an interrupt by presenting its number, which retires that source.

Software reaches the registers through a 32-bit port with single-cycle access. Writes take effect on the clock edge. Read data is combinational from the byte offset, and only the low 8 address bits are decoded.

Top module: `pic2_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_level` is 0.
- R2: A rising edge on line n (1 to 15) sets pending bit n (offset 0x04) when broadcast bit n is clear. A line held high sets the bit only once; after a clear it stays clear.
- R3: When broadcast bit n (offset 0x14) is set, an edge on line n sets bit n of the force register (offset 0x80) and leaves pending bit n unchanged.
- R4: Source n is active when (pending[n] OR force[n]) AND mask[n] (mask at offset 0x40). `irq_level` is 0 when no source is active. It is registered and shows a state change one cycle after the edge that made that change.
- R5: Group bit n (offset 0x00) set to 1 puts line n in the high group. When any active source is in the high group, `irq_level` is the highest active index within that group. Otherwise it is the highest active index in the low group.
- R6: Bit 0 is never stored, and only bits 15:1 are kept. A write of 0xFFFFFFFF to the group, force alias, mask or broadcast register reads back 0x0000FFFE.
- R7: A write to offset 0x0C clears each pending bit written as 1. Reads of 0x0C and 0x10 return 0.
- R8: Writes to the pending register (0x04) have no effect.
- R9: A write to 0x80 sets the force bits given in wdata[15:1] and clears the force bits given in wdata[31:17]. The new value is (old OR set) AND NOT clear.
- R10: A write to 0x08 replaces the whole force register with wdata[15:1]. Offset 0x08 reads the same value as 0x80.
- R11: An acknowledge with number n clears bit n of both pending and force. An acknowledge of 0 changes nothing.
- R12: Offset 0xC0 keeps wdata[3:0]. Every other offset, including the per-processor slots above 0x40, 0x80 and 0xC0, reads 0 and ignores writes.
- R13: A line edge in the same cycle as a clear or acknowledge of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Interrupt lines; bit 0 is ignored |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Number of the interrupt being acknowledged |
| irq_level | output | 4 | Request level presented to the processor |

## Verification
The acknowledge and pending-protection properties assume no line edge arrives in the same cycle, because an edge would legally set the bit again. Those properties are therefore written only for cycles with no edge. The priority properties assume the group and active sets sampled one cycle earlier decide the level. The bench drives every input on the falling edge, holds a strobe for exactly one cycle, and makes simultaneous edges only in the one scenario aimed at R13.

// File: rtl/pic2_pkg.sv
package pic2_pkg;
    localparam int unsigned PIC_LINES = 16;
    localparam int unsigned PIC_DW    = 32;
    localparam int unsigned PIC_AW    = 8;
    localparam int unsigned PIC_LW    = $clog2(PIC_LINES);
    localparam int unsigned PIC_EXT_W = 4;
    localparam int unsigned PIC_HALF  = PIC_DW / 2;

    // byte offsets; the decoder compares addr with the low two bits cleared
    localparam logic [PIC_AW-1:0] OFF_GROUP  = 8'h00;
    localparam logic [PIC_AW-1:0] OFF_PEND   = 8'h04;
    localparam logic [PIC_AW-1:0] OFF_FALIAS = 8'h08;
    localparam logic [PIC_AW-1:0] OFF_CLR    = 8'h0C;
    localparam logic [PIC_AW-1:0] OFF_MPST   = 8'h10;
    localparam logic [PIC_AW-1:0] OFF_BCAST  = 8'h14;
    localparam logic [PIC_AW-1:0] OFF_MASK   = 8'h40;
    localparam logic [PIC_AW-1:0] OFF_FRC    = 8'h80;
    localparam logic [PIC_AW-1:0] OFF_EXT    = 8'hC0;

    // bit 0 of every line vector is reserved
    localparam logic [PIC_LINES-1:0] PIC_KEEP = {{(PIC_LINES-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [PIC_LINES-1:0] group;
        logic [PIC_LINES-1:0] pend;
        logic [PIC_LINES-1:0] frc;
        logic [PIC_LINES-1:0] bcast;
        logic [PIC_LINES-1:0] mask;
        logic [PIC_EXT_W-1:0] ext;
    } pic_state_t;
endpackage

// File: rtl/pic2_edge.sv
module pic2_edge
    import pic2_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIC_LINES-1:0] irq_in,
    output logic [PIC_LINES-1:0] ev
);
    logic [PIC_LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = irq_in;
        ev     = irq_in & ~prev_q & PIC_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pic2_regs.sv
module pic2_regs
    import pic2_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PIC_AW-1:0]    addr,
    input  logic [PIC_DW-1:0]    wdata,
    input  logic [PIC_LINES-1:0] ev,
    input  logic                 ack_valid,
    input  logic [PIC_LW-1:0]    ack_num,
    output pic_state_t           st_q,
    output logic [PIC_DW-1:0]    rdata
);
    pic_state_t           st_d;
    logic [PIC_AW-1:0]    word;
    logic [PIC_LINES-1:0] set_bits, clr_bits, ack_bits, ev_frc, ev_pend;
    logic                 unused_bits;

    assign word        = {addr[PIC_AW-1:2], 2'b00};
    assign unused_bits = ^{addr[1:0], wdata[PIC_HALF]};

    always_comb begin
        st_d     = st_q;
        set_bits = wdata[PIC_LINES-1:0] & PIC_KEEP;
        clr_bits = wdata[PIC_HALF+PIC_LINES-1:PIC_HALF] & PIC_KEEP;
        ack_bits = ack_valid ? ({{(PIC_LINES-1){1'b0}}, 1'b1} << ack_num) : '0;
        ev_frc   = ev & st_q.bcast & PIC_KEEP;
        ev_pend  = ev & ~st_q.bcast & PIC_KEEP;

        if (wr_en) begin
            if (word == OFF_GROUP)  st_d.group = set_bits;
            if (word == OFF_FALIAS) st_d.frc   = set_bits;
            if (word == OFF_CLR)    st_d.pend  = st_q.pend & ~set_bits;
            if (word == OFF_BCAST)  st_d.bcast = set_bits;
            if (word == OFF_MASK)   st_d.mask  = set_bits;
            if (word == OFF_FRC)    st_d.frc   = (st_q.frc | set_bits) & ~clr_bits;
            if (word == OFF_EXT)    st_d.ext   = wdata[PIC_EXT_W-1:0];
        end

        // acknowledge retires, then input events set (a set wins)
        st_d.pend = (st_d.pend & ~ack_bits) | ev_pend;
        st_d.frc  = (st_d.frc  & ~ack_bits) | ev_frc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (word == OFF_GROUP)  rdata = PIC_DW'(st_q.group);
        if (word == OFF_PEND)   rdata = PIC_DW'(st_q.pend);
        if (word == OFF_FALIAS) rdata = PIC_DW'(st_q.frc);
        if (word == OFF_BCAST)  rdata = PIC_DW'(st_q.bcast);
        if (word == OFF_MASK)   rdata = PIC_DW'(st_q.mask);
        if (word == OFF_FRC)    rdata = PIC_DW'(st_q.frc);
        if (word == OFF_EXT)    rdata = PIC_DW'(st_q.ext);
    end
endmodule

// File: rtl/pic2_prio.sv
module pic2_prio
    import pic2_pkg::*;
(
    input  logic [PIC_LINES-1:0] group,
    input  logic [PIC_LINES-1:0] pend,
    input  logic [PIC_LINES-1:0] frc,
    input  logic [PIC_LINES-1:0] mask,
    output logic [PIC_LINES-1:0] active,
    output logic [PIC_LW-1:0]    sel
);
    logic [PIC_LINES-1:0] hi, lo, win;
    logic [PIC_LW-1:0]    cand [PIC_LINES];
    logic                 unused_win0;

    assign active      = (pend | frc) & mask & PIC_KEEP;
    assign hi          = active & group;
    assign lo          = active & ~group;
    assign win         = (hi != '0) ? hi : lo;
    assign unused_win0 = win[0];
    assign cand[0]     = '0;

    for (genvar g = 1; g < PIC_LINES; g++) begin : g_chain
        assign cand[g] = win[g] ? PIC_LW'(g) : cand[g-1];
    end

    assign sel = cand[PIC_LINES-1];
endmodule

// File: rtl/pic2_ctrl.sv
module pic2_ctrl
    import pic2_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIC_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [PIC_AW-1:0]    bus_addr,
    input  logic [PIC_DW-1:0]    bus_wdata,
    output logic [PIC_DW-1:0]    bus_rdata,
    input  logic                 ack_valid,
    input  logic [PIC_LW-1:0]    ack_num,
    output logic [PIC_LW-1:0]    irq_level
);
    pic_state_t           st_q;
    logic [PIC_LINES-1:0] ev_w, active_w, group_w, pend_w, frc_w, mask_w;
    logic [PIC_LW-1:0]    sel_w, lvl_d, lvl_q;
    logic [PIC_LINES-1:0] bcast_w;
    logic [PIC_EXT_W-1:0] ext_w;
    logic                 unused_st;

    assign group_w   = st_q.group;
    assign pend_w    = st_q.pend;
    assign frc_w     = st_q.frc;
    assign mask_w    = st_q.mask;
    assign bcast_w   = st_q.bcast;
    assign ext_w     = st_q.ext;
    assign unused_st = ^{bcast_w, ext_w};

    pic2_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .ev     (ev_w)
    );

    pic2_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ev        (ev_w),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .st_q      (st_q),
        .rdata     (bus_rdata)
    );

    pic2_prio u_prio (
        .group  (group_w),
        .pend   (pend_w),
        .frc    (frc_w),
        .mask   (mask_w),
        .active (active_w),
        .sel    (sel_w)
    );

    always_comb lvl_d = sel_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign irq_level = lvl_q;
endmodule

// File: rtl/pic2_ctrl_chk.sv
module pic2_ctrl_chk
    import pic2_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [PIC_AW-1:0]    bus_addr,
    input logic [PIC_DW-1:0]    bus_rdata,
    input logic                 ack_valid,
    input logic [PIC_LW-1:0]    ack_num,
    input logic [PIC_LW-1:0]    irq_level,
    input logic [PIC_LINES-1:0] ev,
    input logic [PIC_LINES-1:0] active,
    input logic [PIC_LINES-1:0] group,
    input logic [PIC_LINES-1:0] pend,
    input logic [PIC_LINES-1:0] frc
);
    logic                 hi_any_q, lo_any_q;
    logic [PIC_LINES-1:0] group_snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_any_q     <= 1'b0;
            lo_any_q     <= 1'b0;
            group_snap_q <= '0;
        end else begin
            hi_any_q     <= (active & group) != '0;
            lo_any_q     <= (active & ~group) != '0;
            group_snap_q <= group;
        end
    end

    // R4: nothing active means level 0 on the next cycle
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (irq_level == '0));

    // R5: a high-group source wins
    a_r5_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hi_any_q |-> (irq_level != '0) && group_snap_q[irq_level]);

    // R5: otherwise a low-group source is presented
    a_r5_low_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_any_q && lo_any_q) |-> (irq_level != '0) && !group_snap_q[irq_level]);

    // R8: pending ignores bus writes
    a_r8_pend_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_PEND && ev == '0 && !ack_valid) |=> $stable(pend));

    // R11: acknowledge retires the bit
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ev == '0) |=> !pend[$past(ack_num)] && !frc[$past(ack_num)]);

    // R6: bit 0 is never held
    a_r6_bit0_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0] && !frc[0] && !group[0]);

    // R7: clear and status offsets read zero
    a_r7_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CLR || bus_addr == OFF_MPST) |-> (bus_rdata == '0));
endmodule

bind pic2_ctrl pic2_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .irq_level (irq_level),
    .ev        (ev_w),
    .active    (active_w),
    .group     (group_w),
    .pend      (pend_w),
    .frc       (frc_w)
);

// File: tb/test_pic2_ctrl.sv
module test_pic2_ctrl;
    import pic2_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [PIC_LINES-1:0] irq_in = '0;
    logic                 bus_wr = 1'b0;
    logic [PIC_AW-1:0]    bus_addr = '0;
    logic [PIC_DW-1:0]    bus_wdata = '0;
    logic [PIC_DW-1:0]    bus_rdata;
    logic                 ack_valid = 1'b0;
    logic [PIC_LW-1:0]    ack_num = '0;
    logic [PIC_LW-1:0]    irq_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic2_ctrl i_pic2_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .irq_level (irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input int n);
        @(negedge clk); irq_in[n] = 1'b1;
        @(negedge clk); irq_in[n] = 1'b0;
    endtask

    task automatic ack(input int n);
        @(negedge clk); ack_valid = 1'b1; ack_num = PIC_LW'(n);
        @(negedge clk); ack_valid = 1'b0;
    endtask

    task automatic lvl_check(input string req, input int exp);
        @(negedge clk);
        check(req, 32'(irq_level), 32'(exp));
    endtask

    task automatic t_reset();
        check("R1 level", 32'(irq_level), 0);
        rd_check("R1 group", 8'h00, 0);
        rd_check("R1 pend", 8'h04, 0);
        rd_check("R1 force", 8'h80, 0);
        rd_check("R1 bcast", 8'h14, 0);
        rd_check("R1 mask", 8'h40, 0);
        rd_check("R1 ext", 8'hC0, 0);
    endtask

    task automatic t_pending();
        @(negedge clk); irq_in[5] = 1'b1;
        rd_check("R2 edge sets", 8'h04, 32'h20);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_check("R8 pend ro", 8'h04, 32'h20);
        wr(8'h0C, 32'h20);
        repeat (3) @(negedge clk);
        rd_check("R2 held line", 8'h04, 0);
        @(negedge clk); irq_in[5] = 1'b0;
    endtask

    task automatic t_priority();
        pulse(3); pulse(9);
        lvl_check("R4 masked", 0);
        wr(8'h40, 32'h0208);
        check("R4 registered", 32'(irq_level), 0);
        lvl_check("R5 low highest", 9);
        wr(8'h00, 32'h1008);
        lvl_check("R5 high wins", 3);
        wr(8'h00, 32'h0);
        lvl_check("R5 back to low", 9);
    endtask

    task automatic t_ack();
        ack(9);
        rd_check("R11 ack pend", 8'h04, 32'h08);
        lvl_check("R11 level", 3);
        ack(3);
        lvl_check("R11 level idle", 0);
        pulse(1);
        ack(0);
        rd_check("R11 ack zero", 8'h04, 32'h02);
        wr(8'h0C, 32'hFFFF);
    endtask

    task automatic t_force();
        wr(8'h80, 32'h0000_00F0);
        rd_check("R9 set", 8'h80, 32'hF0);
        wr(8'h80, 32'h0030_0100);
        rd_check("R9 set clear", 8'h80, 32'h1C0);
        wr(8'h08, 32'h0000_FFFF);
        rd_check("R10 alias", 8'h80, 32'hFFFE);
        lvl_check("R4 forced active", 9);
        wr(8'h08, 32'h0000_0003);
        rd_check("R10 alias read", 8'h08, 32'h02);
        wr(8'h08, 32'h0);
        wr(8'h40, 32'h0);
    endtask

    task automatic t_bit0();
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_check("R6 group", 8'h00, 32'hFFFE);
        rd_check("R6 mask", 8'h40, 32'hFFFE);
        rd_check("R6 bcast", 8'h14, 32'hFFFE);
        rd_check("R6 alias", 8'h08, 32'hFFFE);
        wr(8'h00, 0); wr(8'h40, 0); wr(8'h14, 0); wr(8'h08, 0);
    endtask

    task automatic t_broadcast();
        wr(8'h14, 32'h80);
        pulse(7);
        rd_check("R3 force", 8'h80, 32'h80);
        rd_check("R3 pend", 8'h04, 0);
        wr(8'h40, 32'h80);
        lvl_check("R3 level", 7);
        ack(7);
        rd_check("R3 ack", 8'h80, 0);
        wr(8'h14, 0);
    endtask

    task automatic t_decode();
        wr(8'hC0, 32'hFFFF_FFFF);
        rd_check("R12 ext", 8'hC0, 32'hF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'hC4, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_check("R12 0x44", 8'h44, 0);
        rd_check("R12 0x84", 8'h84, 0);
        rd_check("R12 0xC4", 8'hC4, 0);
        rd_check("R12 0x18", 8'h18, 0);
        rd_check("R12 mask kept", 8'h40, 32'h80);
        rd_check("R12 force kept", 8'h80, 0);
        rd_check("R12 bcast kept", 8'h14, 0);
    endtask

    task automatic t_clear();
        pulse(2);
        rd_check("R7 pend set", 8'h04, 32'h04);
        rd_check("R7 clr reads 0", 8'h0C, 0);
        rd_check("R7 status reads 0", 8'h10, 0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check("R7 clear", 8'h04, 0);
    endtask

    task automatic t_collide();
        pulse(4);
        @(negedge clk);
        irq_in[4] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h10;
        @(negedge clk);
        bus_wr = 1'b0; irq_in[4] = 1'b0;
        rd_check("R13 set wins clear", 8'h04, 32'h10);
        @(negedge clk);
        irq_in[4] = 1'b1; ack_valid = 1'b1; ack_num = 4'd4;
        @(negedge clk);
        ack_valid = 1'b0; irq_in[4] = 1'b0;
        rd_check("R13 set wins ack", 8'h04, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_priority();
        t_ack();
        t_force();
        t_bit0();
        t_broadcast();
        t_decode();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule